// File: doc/BRIEF.md
# Endpoint Queue Head Transfer Manager

This block keeps the per-endpoint descriptor records of a USB device controller's DMA engine up to date. All endpoint queue heads sit in one flat array in system memory. The array starts at a software-programmed list base, and each endpoint number and direction selects its slot directly, with no list walking. The block computes a slot address from the requested endpoint number and direction. It then runs one of two word-by-word memory sequences over a simple valid/ready request port with a read-response channel.

A prime command records a transfer descriptor's address in the queue head's current-descriptor word. It then copies the seven descriptor words into the staging overlay inside the queue head, so later packet handling can find them quickly. A complete command reads the current-descriptor pointer back from the queue head. It writes the final status into the token/status word of the descriptor that the pointer names. The overlay copy is left untouched. Only one command runs at a time. A command presented while the block is busy is held off until the block can take it. A request for an endpoint that does not exist is refused without touching memory.

Top module: `ep_qh_mgr`

## Requirements
- R1: `qh_addr_o` equals the aligned list base plus (2 × `cmd_ep_i` + `cmd_dir_i`) × 64. Direction 0 is a receive (OUT) endpoint and direction 1 is a transmit (IN) endpoint.
- R2: `cfg_err_o` is high exactly when any of `list_base_i[10:0]` is set. Those low 11 bits are treated as zero in every address the block forms.
- R3: Prime is `cmd_op_i` = 0. Its first memory access writes `cmd_dtd_i` to queue-head word 1 (slot address + 4).
- R4: After that first write, prime reads descriptor words 0 to 6 at `cmd_dtd_i` + 4k in ascending order. Each read is followed by a write of the returned word to queue-head word 2+k (slot address + 8 + 4k), for 15 accesses in all.
- R5: Complete is `cmd_op_i` = 1. It reads queue-head word 1, then writes `cmd_status_i` to the returned pointer + 4, for 2 accesses in all. No overlay word of the queue head is written.
- R6: An accepted command with `cmd_ep_i` ≥ 6 gives a one-cycle `err_o` pulse in the next cycle. It makes no memory request, does not raise `busy_o` and gives no `done_o`.
- R7: `busy_o` is high from the cycle after a valid command is accepted until its last memory handshake. `cmd_ready_o` is the inverse of `busy_o`. `done_o` pulses for exactly one cycle, in the cycle after the last handshake.
- R8: A command held valid while the block is busy is accepted in the first cycle the block is ready, and it is then executed in full.
- R9: At most one memory access is outstanding, so `mem_req_valid_o` stays low while a read response is awaited. A request that is stalled by `mem_req_ready_i` keeps its valid, address, write flag and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| list_base_i | input | 32 | Base address of the queue head array |
| cfg_err_o | output | 1 | List base is not on a 2 kB boundary |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| cmd_op_i | input | 1 | 0 = prime, 1 = complete |
| cmd_ep_i | input | 3 | Endpoint number |
| cmd_dir_i | input | 1 | 0 = OUT, 1 = IN |
| cmd_dtd_i | input | 32 | Descriptor address (prime) |
| cmd_status_i | input | 32 | Final status word (complete) |
| qh_addr_o | output | 32 | Queue head slot address for the presented endpoint |
| busy_o | output | 1 | A command sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence finishes |
| err_o | output | 1 | One-cycle pulse when an endpoint is out of range |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | 32 | Byte address of the word |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read data |

## Verification
The completion pulse of one command and the acceptance of the next command can fall in the same cycle. The ready signal rises in the cycle that `done_o` is high, so a held request is taken at the following edge. The bench starts a prime and at once holds a complete command valid for the same endpoint. In the first cycle the block reports ready, the bench checks that `done_o` is also high. It then checks that the complete ran in full: it used the pointer that the prime had just stored, and the memory trace holds exactly 17 accesses. The memory model stalls requests on a fixed pattern, so this overlap is also exercised while requests are stalled.

// File: rtl/ep_qh_pkg.sv
package ep_qh_pkg;
  localparam int unsigned QH_CUR_WORD  = 1;  // current-descriptor pointer
  localparam int unsigned QH_OVL_WORD  = 2;  // first overlay word
  localparam int unsigned DTD_WORDS    = 7;  // next, token/status, 5 buffer ptrs
  localparam int unsigned DTD_STS_WORD = 1;  // token/status word in a descriptor

  typedef enum logic {
    OP_PRIME    = 1'b0,
    OP_COMPLETE = 1'b1
  } qh_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_P_CUR,
    S_P_RD,
    S_P_RWAIT,
    S_P_WR,
    S_C_RD,
    S_C_RWAIT,
    S_C_WR
  } qh_state_e;
endpackage

// File: rtl/ep_qh_addr_gen.sv
module ep_qh_addr_gen #(
  parameter int AW         = 32,
  parameter int NUM_EP     = 6,
  parameter int EP_W       = 3,
  parameter int SLOT_BITS  = 6,
  parameter int ALIGN_BITS = 11
) (
  input  logic [AW-1:0]   base_i,
  input  logic [EP_W-1:0] ep_i,
  input  logic            dir_i,
  output logic [AW-1:0]   qh_addr_o,
  output logic            ep_ok_o,
  output logic            misalign_o
);
  localparam int IDX_W = EP_W + 1;

  logic [AW-1:0]    base_al;
  logic [IDX_W-1:0] idx;

  assign base_al    = {base_i[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign idx        = {ep_i, dir_i};  // even = OUT, odd = IN
  assign qh_addr_o  = base_al + (AW'(idx) << SLOT_BITS);
  assign ep_ok_o    = int'(ep_i) < NUM_EP;
  assign misalign_o = |base_i[ALIGN_BITS-1:0];
endmodule

// File: rtl/ep_qh_req_gen.sv
module ep_qh_req_gen
  import ep_qh_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 3
) (
  input  qh_state_e      state_i,
  input  logic [BW-1:0]  beat_i,
  input  logic [AW-1:0]  qh_i,
  input  logic [AW-1:0]  dtd_i,
  input  logic [DW-1:0]  sts_i,
  input  logic [DW-1:0]  rdata_i,
  output logic           valid_o,
  output logic           we_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o
);
  localparam logic [AW-1:0] CUR_OFS = AW'(QH_CUR_WORD * 4);
  localparam logic [AW-1:0] OVL_OFS = AW'(QH_OVL_WORD * 4);
  localparam logic [AW-1:0] STS_OFS = AW'(DTD_STS_WORD * 4);

  logic [AW-1:0] beat_ofs;
  assign beat_ofs = AW'(beat_i) << 2;

  always_comb begin
    valid_o = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      S_P_CUR: begin
        valid_o = 1'b1;
        we_o    = 1'b1;
        addr_o  = qh_i + CUR_OFS;
        wdata_o = DW'(dtd_i);
      end
      S_P_RD: begin
        valid_o = 1'b1;
        addr_o  = dtd_i + beat_ofs;
      end
      S_P_WR: begin
        valid_o = 1'b1;
        we_o    = 1'b1;
        addr_o  = qh_i + OVL_OFS + beat_ofs;
        wdata_o = rdata_i;
      end
      S_C_RD: begin
        valid_o = 1'b1;
        addr_o  = qh_i + CUR_OFS;
      end
      S_C_WR: begin
        valid_o = 1'b1;
        we_o    = 1'b1;
        addr_o  = AW'(rdata_i) + STS_OFS;  // real descriptor, not overlay
        wdata_o = sts_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ep_qh_seq.sv
module ep_qh_seq
  import ep_qh_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic           cmd_op_i,
  input  logic           ep_ok_i,
  input  logic [AW-1:0]  qh_addr_i,
  input  logic [AW-1:0]  dtd_i,
  input  logic [DW-1:0]  sts_i,
  input  logic           hs_i,
  input  logic           rsp_valid_i,
  input  logic [DW-1:0]  rsp_rdata_i,
  output logic           cmd_ready_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output qh_state_e      state_o,
  output logic [BW-1:0]  beat_o,
  output logic [AW-1:0]  qh_q_o,
  output logic [AW-1:0]  dtd_q_o,
  output logic [DW-1:0]  sts_q_o,
  output logic [DW-1:0]  rdata_q_o
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(DTD_WORDS - 1);

  qh_state_e     state_q;
  logic [BW-1:0] beat_q;
  logic [AW-1:0] qh_q, dtd_q;
  logic [DW-1:0] sts_q, rdata_q;
  logic          done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      qh_q    <= '0;
      dtd_q   <= '0;
      sts_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          qh_q   <= qh_addr_i;
          dtd_q  <= dtd_i;
          sts_q  <= sts_i;
          beat_q <= '0;
          if (!ep_ok_i)                             err_q   <= 1'b1;
          else if (qh_op_e'(cmd_op_i) == OP_COMPLETE) state_q <= S_C_RD;
          else                                      state_q <= S_P_CUR;
        end
        S_P_CUR: if (hs_i) state_q <= S_P_RD;
        S_P_RD:  if (hs_i) state_q <= S_P_RWAIT;
        S_P_RWAIT: if (rsp_valid_i) begin
          rdata_q <= rsp_rdata_i;
          state_q <= S_P_WR;
        end
        S_P_WR: if (hs_i) begin
          if (beat_q == LAST_BEAT) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            beat_q  <= beat_q + 1'b1;
            state_q <= S_P_RD;
          end
        end
        S_C_RD: if (hs_i) state_q <= S_C_RWAIT;
        S_C_RWAIT: if (rsp_valid_i) begin
          rdata_q <= rsp_rdata_i;
          state_q <= S_C_WR;
        end
        S_C_WR: if (hs_i) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign state_o     = state_q;
  assign beat_o      = beat_q;
  assign qh_q_o      = qh_q;
  assign dtd_q_o     = dtd_q;
  assign sts_q_o     = sts_q;
  assign rdata_q_o   = rdata_q;
endmodule

// File: rtl/ep_qh_mgr.sv
module ep_qh_mgr
  import ep_qh_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NUM_EP     = 6,
  parameter int EP_W       = 3,
  parameter int SLOT_BITS  = 6,
  parameter int ALIGN_BITS = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   list_base_i,
  output logic            cfg_err_o,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic            cmd_op_i,
  input  logic [EP_W-1:0] cmd_ep_i,
  input  logic            cmd_dir_i,
  input  logic [AW-1:0]   cmd_dtd_i,
  input  logic [DW-1:0]   cmd_status_i,
  output logic [AW-1:0]   qh_addr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic            mem_req_we_o,
  output logic [AW-1:0]   mem_req_addr_o,
  output logic [DW-1:0]   mem_req_wdata_o,
  input  logic            mem_rsp_valid_i,
  input  logic [DW-1:0]   mem_rsp_rdata_i
);
  localparam int BW = $clog2(DTD_WORDS);

  logic          ep_ok, hs;
  qh_state_e     state;
  logic [BW-1:0] beat;
  logic [AW-1:0] qh_q, dtd_q;
  logic [DW-1:0] sts_q, rdata_q;

  assign hs = mem_req_valid_o & mem_req_ready_i;

  ep_qh_addr_gen #(
    .AW(AW), .NUM_EP(NUM_EP), .EP_W(EP_W),
    .SLOT_BITS(SLOT_BITS), .ALIGN_BITS(ALIGN_BITS)
  ) u_addr (
    .base_i     (list_base_i),
    .ep_i       (cmd_ep_i),
    .dir_i      (cmd_dir_i),
    .qh_addr_o  (qh_addr_o),
    .ep_ok_o    (ep_ok),
    .misalign_o (cfg_err_o)
  );

  ep_qh_seq #(.AW(AW), .DW(DW), .BW(BW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .ep_ok_i     (ep_ok),
    .qh_addr_i   (qh_addr_o),
    .dtd_i       (cmd_dtd_i),
    .sts_i       (cmd_status_i),
    .hs_i        (hs),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_rdata_i (mem_rsp_rdata_i),
    .cmd_ready_o (cmd_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .state_o     (state),
    .beat_o      (beat),
    .qh_q_o      (qh_q),
    .dtd_q_o     (dtd_q),
    .sts_q_o     (sts_q),
    .rdata_q_o   (rdata_q)
  );

  ep_qh_req_gen #(.AW(AW), .DW(DW), .BW(BW)) u_req (
    .state_i (state),
    .beat_i  (beat),
    .qh_i    (qh_q),
    .dtd_i   (dtd_q),
    .sts_i   (sts_q),
    .rdata_i (rdata_q),
    .valid_o (mem_req_valid_o),
    .we_o    (mem_req_we_o),
    .addr_o  (mem_req_addr_o),
    .wdata_o (mem_req_wdata_o)
  );
endmodule

// File: rtl/ep_qh_mgr_chk.sv
module ep_qh_mgr_chk #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NUM_EP = 6,
  parameter int EP_W   = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic            cmd_ready_o,
  input logic            cmd_op_i,
  input logic [EP_W-1:0] cmd_ep_i,
  input logic [AW-1:0]   cmd_dtd_i,
  input logic [AW-1:0]   qh_addr_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic            mem_req_we_o,
  input logic [AW-1:0]   mem_req_addr_o,
  input logic [DW-1:0]   mem_req_wdata_o,
  input logic            mem_rsp_valid_i
);
  assert_prime_first_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !cmd_op_i && int'(cmd_ep_i) < NUM_EP)
    |=> (mem_req_valid_o && mem_req_we_o
         && mem_req_addr_o == $past(qh_addr_o) + AW'(4)
         && mem_req_wdata_o == DW'($past(cmd_dtd_i))));

  assert_reject_no_access_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && int'(cmd_ep_i) >= NUM_EP)
    |=> (err_o && !mem_req_valid_o && !busy_o));

  assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i && cmd_ready_o && int'(cmd_ep_i) >= NUM_EP));

  assert_done_ends_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_req_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i)
    |=> (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
         && $stable(mem_req_wdata_o)));

  assert_one_outstanding_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> !mem_req_valid_o);
endmodule

bind ep_qh_mgr ep_qh_mgr_chk #(
  .AW(AW), .DW(DW), .NUM_EP(NUM_EP), .EP_W(EP_W)
) u_chk (.*);

// File: tb/ep_qh_mgr_tb.sv
module ep_qh_mgr_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 32, DW = 32, EP_W = 3, NUM_EP = 6;
  localparam int MEM_WORDS = 1024, TR_MAX = 128;
  localparam logic [31:0] BASE = 32'h0000_0800;

  typedef struct packed {
    logic        op;
    logic [2:0]  ep;
    logic        dir;
    logic [31:0] dtd;     // prime: descriptor; complete: expected stored pointer
    logic [31:0] sts;
    logic [31:0] exp_qh;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 3'd0, 1'b0, 32'h100, 32'h0,         32'h800},
    '{1'b0, 3'd0, 1'b1, 32'h140, 32'h0,         32'h840},
    '{1'b0, 3'd5, 1'b1, 32'h180, 32'h0,         32'hAC0},
    '{1'b0, 3'd3, 1'b0, 32'h1C0, 32'h0,         32'h980},
    '{1'b1, 3'd5, 1'b1, 32'h180, 32'h8000_0080, 32'hAC0},
    '{1'b1, 3'd0, 1'b0, 32'h100, 32'h0000_1234, 32'h800}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] list_base = BASE;
  logic cfg_err, cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0, cmd_dir = 1'b0;
  logic [EP_W-1:0] cmd_ep = '0;
  logic [AW-1:0] cmd_dtd = '0, qh_addr, mem_addr;
  logic [DW-1:0] cmd_sts = '0, mem_wdata, rsp_d;
  logic busy, done, err, mem_valid, mem_we, rdy, rsp_v;

  int total = 0, bad = 0;
  int done_cnt = 0, viol_cnt = 0, stall_cnt = 0;
  int tr_n;
  int unsigned cyc;
  logic [31:0] mem [MEM_WORDS];
  logic        tr_we   [TR_MAX];
  logic [31:0] tr_addr [TR_MAX];

  always #2.5 clk = ~clk;

  ep_qh_mgr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .list_base_i(list_base), .cfg_err_o(cfg_err),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_ep_i(cmd_ep), .cmd_dir_i(cmd_dir), .cmd_dtd_i(cmd_dtd),
    .cmd_status_i(cmd_sts), .qh_addr_o(qh_addr), .busy_o(busy), .done_o(done),
    .err_o(err), .mem_req_valid_o(mem_valid), .mem_req_ready_i(rdy),
    .mem_req_we_o(mem_we), .mem_req_addr_o(mem_addr), .mem_req_wdata_o(mem_wdata),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_rdata_i(rsp_d)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  // memory model: stalls on a fixed pattern, one-cycle read latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= init_word(i);
      rdy <= 1'b0; rsp_v <= 1'b0; rsp_d <= '0; cyc <= 0; tr_n <= 0;
    end else begin
      cyc   <= cyc + 1;
      rdy   <= (cyc % 3) != 1;
      rsp_v <= 1'b0;
      if (mem_valid && rdy) begin
        tr_we[tr_n]   <= mem_we;
        tr_addr[tr_n] <= mem_addr;
        tr_n          <= tr_n + 1;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else begin
          rsp_v <= 1'b1;
          rsp_d <= mem[mem_addr[11:2]];
        end
      end
    end
  end

  // port monitor
  logic        prev_stall = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (rsp_v && mem_valid) viol_cnt++;
      if (prev_stall && !(mem_valid && mem_addr == p_addr && mem_we == p_we
                          && mem_wdata == p_wdata)) viol_cnt++;
      prev_stall = mem_valid && !rdy;
      if (prev_stall) stall_cnt++;
      p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic op, input logic [2:0] ep, input logic dir,
                      input logic [31:0] dtd, input logic [31:0] sts);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ep = ep; cmd_dir = dir;
    cmd_dtd = dtd; cmd_sts = sts;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  task automatic check_prime(input int b, input logic [31:0] qh, input logic [31:0] dtd);
    chk(tr_n - b == 15, "R4 access count", 32'(tr_n - b), 32'd15);
    chk(tr_we[b] && tr_addr[b] == qh + 4, "R3 first write addr", tr_addr[b], qh + 4);
    chk(rd(qh + 4) == dtd, "R3 current pointer", rd(qh + 4), dtd);
    for (int k = 0; k < 7; k++) begin
      chk(!tr_we[b+1+2*k] && tr_addr[b+1+2*k] == dtd + 32'(4*k), "R4 read order",
          tr_addr[b+1+2*k], dtd + 32'(4*k));
      chk(tr_we[b+2+2*k] && tr_addr[b+2+2*k] == qh + 32'(8+4*k), "R4 write order",
          tr_addr[b+2+2*k], qh + 32'(8+4*k));
      chk(rd(qh + 32'(8+4*k)) == init_word(int'(dtd >> 2) + k), "R4 overlay data",
          rd(qh + 32'(8+4*k)), init_word(int'(dtd >> 2) + k));
    end
  endtask

  task automatic check_complete(input int b, input logic [31:0] qh,
                                input logic [31:0] ptr, input logic [31:0] sts);
    chk(tr_n - b == 2, "R5 access count", 32'(tr_n - b), 32'd2);
    chk(!tr_we[b] && tr_addr[b] == qh + 4, "R5 pointer read", tr_addr[b], qh + 4);
    chk(tr_we[b+1] && tr_addr[b+1] == ptr + 4, "R5 status write addr",
        tr_addr[b+1], ptr + 4);
    chk(rd(ptr + 4) == sts, "R5 status data", rd(ptr + 4), sts);
    chk(rd(qh + 12) == init_word(int'(ptr >> 2) + 1), "R5 overlay untouched",
        rd(qh + 12), init_word(int'(ptr >> 2) + 1));
  endtask

  initial begin
    int b, d0;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy && !mem_valid && !done && !err, "R7 reset state",
        {27'd0, cmd_ready, busy, mem_valid, done, err}, 32'h10);
    chk(!cfg_err, "R2 aligned base", 32'(cfg_err), 32'd0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      b = tr_n;
      send(VECS[v].op, VECS[v].ep, VECS[v].dir, VECS[v].dtd, VECS[v].sts);
      chk(qh_addr == VECS[v].exp_qh, "R1 slot address", qh_addr, VECS[v].exp_qh);
      chk(busy && !cmd_ready, "R7 busy after accept", 32'(busy), 32'd1);
      wait_done(ok);
      chk(ok, "R7 done seen", 32'(ok), 32'd1);
      chk(!busy && cmd_ready, "R7 idle at done", 32'(busy), 32'd0);
      @(negedge clk);
      chk(!done, "R7 done one cycle", 32'(done), 32'd0);
      if (!VECS[v].op) check_prime(b, VECS[v].exp_qh, VECS[v].dtd);
      else check_complete(b, VECS[v].exp_qh, VECS[v].dtd, VECS[v].sts);
    end

    // R6: out-of-range endpoints
    b = tr_n; d0 = done_cnt;
    send(1'b0, 3'd6, 1'b0, 32'h300, 32'h0);
    chk(err && !busy, "R6 err pulse ep6", 32'(err), 32'd1);
    @(negedge clk);
    chk(!err, "R6 err one cycle", 32'(err), 32'd0);
    send(1'b1, 3'd7, 1'b1, 32'h300, 32'hDEAD);
    chk(err, "R6 err pulse ep7", 32'(err), 32'd1);
    repeat (6) @(negedge clk);
    chk(tr_n == b, "R6 no memory access", 32'(tr_n - b), 32'd0);
    chk(done_cnt == d0, "R6 no done", 32'(done_cnt - d0), 32'd0);

    // R8: complete held while prime runs; done and accept coincide
    b = tr_n;
    send(1'b0, 3'd2, 1'b0, 32'h200, 32'h0);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_ep = 3'd2; cmd_dir = 1'b0;
    cmd_dtd = 32'h0; cmd_sts = 32'h0000_0077;
    while (!cmd_ready) @(negedge clk);
    chk(done, "R8 done with ready", 32'(done), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy, "R8 held cmd accepted", 32'(busy), 32'd1);
    wait_done(ok);
    chk(ok, "R8 held cmd done", 32'(ok), 32'd1);
    chk(tr_n - b == 17, "R8 total accesses", 32'(tr_n - b), 32'd17);
    chk(rd(32'h204) == 32'h77, "R8 status via new pointer", rd(32'h204), 32'h77);

    // R2: misaligned base flagged, low bits ignored
    @(negedge clk);
    list_base = 32'h0000_0A5C; cmd_ep = 3'd2; cmd_dir = 1'b1;
    @(negedge clk);
    chk(cfg_err, "R2 misalign flag", 32'(cfg_err), 32'd1);
    chk(qh_addr == 32'h940, "R2 low bits ignored", qh_addr, 32'h940);
    list_base = BASE;
    @(negedge clk);
    chk(!cfg_err, "R2 flag clears", 32'(cfg_err), 32'd0);

    chk(viol_cnt == 0, "R9 port discipline", 32'(viol_cnt), 32'd0);
    chk(stall_cnt > 0, "R9 stalls exercised", 32'(stall_cnt), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule